// File: doc/BRIEF.md
# Multichannel ADC Frame Receiver

This block takes conversion frames from a sigma-delta converter that owns the serial link. The converter drives a free-running data clock, a frame strobe that is high for a single clock period, and one or two serial data lanes. Capture runs directly on the incoming data clock. The strobe arms a shifter. Eight channel words are collected MSB first, and shifting stops after the last word, so the bits the converter keeps clocking out afterwards are dropped.

Each finished word crosses into the system clock domain through a small gray-pointer FIFO. There it appears as a one-cycle valid pulse with a 3-bit channel index. A frame-done pulse accompanies the channel 7 word. Two inputs select the lane count and the sampling edge. Both are meant to be static while a frame is in flight. A sticky overrun flag records a strobe that cuts into an unfinished frame.

Top module: `adc_frame_rx`

## Requirements
- R1: A data-clock sampling edge that sees `strobe_i` high starts a frame. The first data bit is taken on the next sampling edge. Every word is `WORD_W` bits, most significant bit first.
- R2: With `dual_lane_i`=0, lane bit 0 carries channels 0 through 7 back to back, in that order, and lane bit 1 is ignored.
- R3: With `dual_lane_i`=1, lane bit 0 carries channels 0 to 3 and lane bit 1 carries channels 4 to 7 simultaneously. Words are delivered in the order 0,4,1,5,2,6,3,7.
- R4: After the last word of a frame, further data-clock cycles with the strobe low produce no output words.
- R5: With `rise_edge_i`=1, strobe and lanes are sampled on rising data-clock edges. With `rise_edge_i`=0 they are sampled on falling edges.
- R6: Each captured word appears once on `word_o`, with its index on `chan_o` and a one-system-cycle `valid_o` pulse.
- R7: `frame_done_o` is high only in the cycle where `valid_o` carries the channel 7 word.
- R8: A strobe that arrives before the current frame's last word has been captured sets `overrun_o`. The flag stays set until reset. The capture restarts at channel 0, and words already completed are still delivered.
- R9: While reset is held and right after it, `valid_o`, `frame_done_o` and `overrun_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk_i | input | 1 | System clock for the output side |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| dclk_i | input | 1 | Free-running data clock from the converter |
| strobe_i | input | 1 | One-period frame strobe |
| lane_i | input | 2 | Serial data lanes (bit 0 = lane 0, bit 1 = lane 1) |
| dual_lane_i | input | 1 | 1 = two-lane frames, 0 = single lane |
| rise_edge_i | input | 1 | 1 = sample on rising edge, 0 = falling edge |
| word_o | output | WORD_W | Received channel word |
| chan_o | output | 3 | Channel index of `word_o` |
| valid_o | output | 1 | One-cycle pulse per delivered word |
| frame_done_o | output | 1 | Pulse with the last word of a frame |
| overrun_o | output | 1 | Sticky frame overrun flag |

## Verification
The bench builds the receiver with `WORD_W`=16 and `FIFO_DEPTH`=4. The short words keep each frame to a few hundred data-clock edges, so all four combinations of lane count and sampling edge fit in one run, along with trailing junk after each frame and a truncated frame that forces an overrun. The data clock runs five times slower than the system clock. In dual-lane mode this lets the back-to-back pair of word pushes drain through the depth-4 FIFO before the next pair arrives.

// File: rtl/adc_rx_pkg.sv
package adc_rx_pkg;
  localparam int unsigned NUM_CHAN = 8;
  localparam int unsigned CHAN_W   = $clog2(NUM_CHAN);
  localparam int unsigned HALF_CH  = NUM_CHAN / 2;
endpackage

// File: rtl/adc_rx_sync.sv
module adc_rx_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/adc_rx_afifo.sv
module adc_rx_afifo #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic          wclk_i,
  input  logic          wen_i,
  input  logic [DW-1:0] wdata_i,
  output logic          wfull_o,
  input  logic          rclk_i,
  input  logic          ren_i,
  output logic [DW-1:0] rdata_o,
  output logic          rempty_o,
  input  logic          rst_ni
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW:0] wbin_q, wgray_q, rbin_q, rgray_q, wgray_rs, rgray_ws;
  logic [AW:0] wbin_n, rbin_n;
  logic        do_wr, do_rd;

  assign do_wr  = wen_i && !wfull_o;
  assign do_rd  = ren_i && !rempty_o;
  assign wbin_n = wbin_q + {{AW{1'b0}}, do_wr};
  assign rbin_n = rbin_q + {{AW{1'b0}}, do_rd};

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else begin
      wbin_q  <= wbin_n;
      wgray_q <= (wbin_n >> 1) ^ wbin_n;
    end
  end

  always_ff @(posedge wclk_i) begin
    if (do_wr) mem[wbin_q[AW-1:0]] <= wdata_i;
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q  <= '0;
      rgray_q <= '0;
    end else begin
      rbin_q  <= rbin_n;
      rgray_q <= (rbin_n >> 1) ^ rbin_n;
    end
  end

  adc_rx_sync #(.W(AW+1)) u_sync_r2w (.clk_i(wclk_i), .rst_ni(rst_ni), .d_i(rgray_q), .q_o(rgray_ws));
  adc_rx_sync #(.W(AW+1)) u_sync_w2r (.clk_i(rclk_i), .rst_ni(rst_ni), .d_i(wgray_q), .q_o(wgray_rs));

  // full: top two gray bits inverted, rest equal
  assign wfull_o  = (wgray_q == {~rgray_ws[AW:AW-1], rgray_ws[AW-2:0]});
  assign rempty_o = (rgray_q == wgray_rs);
  assign rdata_o  = mem[rbin_q[AW-1:0]];
endmodule

// File: rtl/adc_rx_capture.sv
module adc_rx_capture
  import adc_rx_pkg::*;
#(
  parameter int unsigned WORD_W = 32
) (
  input  logic              cap_clk_i,
  input  logic              rst_ni,
  input  logic              strobe_i,
  input  logic [1:0]        lane_i,
  input  logic              dual_i,
  input  logic              full_i,
  output logic              push_o,
  output logic [CHAN_W-1:0] push_chan_o,
  output logic [WORD_W-1:0] push_word_o,
  output logic              active_o,
  output logic              ovr_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W);

  logic              active_q, pend_q, done_now;
  logic [CNT_W-1:0]  bit_q;
  logic [CHAN_W-1:0] idx_q, pend_chan_q, last_idx;
  logic [WORD_W-1:0] sh0_q, sh1_q, pend_word_q, word0, word1;

  assign word0    = {sh0_q[WORD_W-2:0], lane_i[0]};
  assign word1    = {sh1_q[WORD_W-2:0], lane_i[1]};
  assign last_idx = dual_i ? CHAN_W'(HALF_CH-1) : CHAN_W'(NUM_CHAN-1);
  assign done_now = active_q && !strobe_i && (bit_q == CNT_W'(WORD_W-1));

  always_comb begin
    push_o      = 1'b0;
    push_chan_o = idx_q;
    push_word_o = word0;
    if (done_now) begin
      push_o = 1'b1;
    end else if (pend_q) begin
      push_o      = 1'b1;
      push_chan_o = pend_chan_q;
      push_word_o = pend_word_q;
    end
  end

  always_ff @(posedge cap_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q    <= 1'b0;
      pend_q      <= 1'b0;
      bit_q       <= '0;
      idx_q       <= '0;
      pend_chan_q <= '0;
      sh0_q       <= '0;
      sh1_q       <= '0;
      pend_word_q <= '0;
      ovr_o       <= 1'b0;
    end else begin
      pend_q <= done_now && dual_i;
      if (done_now && dual_i) begin
        pend_word_q <= word1;
        pend_chan_q <= idx_q + CHAN_W'(HALF_CH);
      end
      if (push_o && full_i) ovr_o <= 1'b1;
      if (strobe_i) begin
        if (active_q) ovr_o <= 1'b1;
        active_q <= 1'b1;
        bit_q    <= '0;
        idx_q    <= '0;
      end else if (active_q) begin
        sh0_q <= word0;
        sh1_q <= word1;
        if (done_now) begin
          bit_q <= '0;
          idx_q <= idx_q + 1'b1;
          if (idx_q == last_idx) active_q <= 1'b0;
        end else begin
          bit_q <= bit_q + 1'b1;
        end
      end
    end
  end

  assign active_o = active_q;
endmodule

// File: rtl/adc_frame_rx.sv
module adc_frame_rx
  import adc_rx_pkg::*;
#(
  parameter int unsigned WORD_W     = 32,
  parameter int unsigned FIFO_DEPTH = 4
) (
  input  logic              sys_clk_i,
  input  logic              rst_ni,
  input  logic              dclk_i,
  input  logic              strobe_i,
  input  logic [1:0]        lane_i,
  input  logic              dual_lane_i,
  input  logic              rise_edge_i,
  output logic [WORD_W-1:0] word_o,
  output logic [CHAN_W-1:0] chan_o,
  output logic              valid_o,
  output logic              frame_done_o,
  output logic              overrun_o
);
  localparam int unsigned ENT_W = WORD_W + CHAN_W;

  logic              cap_clk, cap_active, cap_ovr, push_en, wfull, rempty;
  logic [CHAN_W-1:0] push_chan;
  logic [WORD_W-1:0] push_word;
  logic [ENT_W-1:0]  rd_ent;
  logic [CHAN_W-1:0] rd_chan;

  // static selection; change only between frames
  assign cap_clk = rise_edge_i ? dclk_i : ~dclk_i;

  adc_rx_capture #(.WORD_W(WORD_W)) u_cap (
    .cap_clk_i  (cap_clk),
    .rst_ni     (rst_ni),
    .strobe_i   (strobe_i),
    .lane_i     (lane_i),
    .dual_i     (dual_lane_i),
    .full_i     (wfull),
    .push_o     (push_en),
    .push_chan_o(push_chan),
    .push_word_o(push_word),
    .active_o   (cap_active),
    .ovr_o      (cap_ovr)
  );

  adc_rx_afifo #(.DW(ENT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .wclk_i  (cap_clk),
    .wen_i   (push_en),
    .wdata_i ({push_chan, push_word}),
    .wfull_o (wfull),
    .rclk_i  (sys_clk_i),
    .ren_i   (!rempty),
    .rdata_o (rd_ent),
    .rempty_o(rempty),
    .rst_ni  (rst_ni)
  );

  adc_rx_sync #(.W(1)) u_sync_ovr (.clk_i(sys_clk_i), .rst_ni(rst_ni), .d_i(cap_ovr), .q_o(overrun_o));

  assign rd_chan = rd_ent[ENT_W-1 -: CHAN_W];

  always_ff @(posedge sys_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o      <= 1'b0;
      frame_done_o <= 1'b0;
      word_o       <= '0;
      chan_o       <= '0;
    end else begin
      valid_o      <= !rempty;
      frame_done_o <= !rempty && (rd_chan == CHAN_W'(NUM_CHAN-1));
      if (!rempty) begin
        word_o <= rd_ent[WORD_W-1:0];
        chan_o <= rd_chan;
      end
    end
  end
endmodule

// File: rtl/adc_frame_rx_chk.sv
module adc_frame_rx_chk (
  input logic       sys_clk_i,
  input logic       rst_ni,
  input logic       cap_clk,
  input logic       strobe_i,
  input logic       cap_active,
  input logic       cap_ovr,
  input logic       push_en,
  input logic       valid_o,
  input logic [2:0] chan_o,
  input logic       frame_done_o,
  input logic       overrun_o
);
  assert_done_with_last_R7: assert property (@(posedge sys_clk_i) disable iff (!rst_ni)
    frame_done_o |-> (valid_o && chan_o == 3'd7));

  assert_overrun_sticky_R8: assert property (@(posedge sys_clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o);

  assert_restart_sets_ovr_R8: assert property (@(posedge cap_clk) disable iff (!rst_ni)
    (strobe_i && cap_active) |=> (cap_ovr && cap_active));

  assert_strobe_arms_R1: assert property (@(posedge cap_clk) disable iff (!rst_ni)
    strobe_i |=> cap_active);

  assert_idle_no_push_R4: assert property (@(posedge cap_clk) disable iff (!rst_ni)
    (!cap_active && !$past(cap_active)) |-> !push_en);
endmodule

bind adc_frame_rx adc_frame_rx_chk u_chk (
  .sys_clk_i   (sys_clk_i),
  .rst_ni      (rst_ni),
  .cap_clk     (cap_clk),
  .strobe_i    (strobe_i),
  .cap_active  (cap_active),
  .cap_ovr     (cap_ovr),
  .push_en     (push_en),
  .valid_o     (valid_o),
  .chan_o      (chan_o),
  .frame_done_o(frame_done_o),
  .overrun_o   (overrun_o)
);

// File: tb/adc_frame_rx_test.sv
module adc_frame_rx_test;
  localparam int W = 16;

  logic         sys_clk = 0, dclk = 0, rst_n = 0;
  logic         strobe = 0, dual_lane = 0, rise_sel = 1;
  logic [1:0]   lane = 0;
  logic [W-1:0] word_o;
  logic [2:0]   chan_o;
  logic         valid_o, frame_done_o, overrun_o;

  int n_tests = 0, n_fail = 0, rx_cnt = 0, exp_total = 0;
  bit done_flag = 0;
  string tag = "R6";
  logic [W+2:0] exp_q[$];

  always #4  sys_clk = ~sys_clk;
  always #20 dclk    = ~dclk;

  adc_frame_rx #(.WORD_W(W), .FIFO_DEPTH(4)) uut (
    .sys_clk_i(sys_clk), .rst_ni(rst_n), .dclk_i(dclk), .strobe_i(strobe),
    .lane_i(lane), .dual_lane_i(dual_lane), .rise_edge_i(rise_sel),
    .word_o(word_o), .chan_o(chan_o), .valid_o(valid_o),
    .frame_done_o(frame_done_o), .overrun_o(overrun_o)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge sys_clk) begin
    if (rst_n && !done_flag) begin
      if (frame_done_o && !valid_o) check(0, "R7", "frame_done without valid", 1, 0);
      if (valid_o) begin
        rx_cnt++;
        if (exp_q.size() == 0) begin
          check(0, "R4", "unexpected word", {29'd0, chan_o}, 0);
        end else begin
          logic [W+2:0] e;
          e = exp_q.pop_front();
          check(chan_o == e[W+2:W], tag, "channel index", chan_o, e[W+2:W]);
          check(word_o == e[W-1:0], tag, "word data", word_o, e[W-1:0]);
          check(frame_done_o == (e[W+2:W] == 3'd7), "R7", "frame_done", frame_done_o, e[W+2:W] == 3'd7);
        end
      end
    end
  end

  task automatic drv_edge();
    if (rise_sel) @(negedge dclk); else @(posedge dclk);
  endtask

  // driver: queues expected words, then plays the frame on the lanes
  task automatic send_frame(input bit dual, input int nbits, input bit trail);
    logic [W-1:0] d[8];
    int k, bi;
    foreach (d[i]) d[i] = W'($urandom);
    for (int j = 0; j < nbits / W; j++) begin
      exp_q.push_back({3'(j), d[j]});
      exp_total++;
      if (dual) begin
        exp_q.push_back({3'(j + 4), d[j + 4]});
        exp_total++;
      end
    end
    dual_lane = dual;
    drv_edge();
    strobe = 1;
    lane   = 2'($urandom);
    for (int b = 0; b < nbits; b++) begin
      drv_edge();
      strobe = 0;
      k  = b / W;
      bi = W - 1 - (b % W);
      lane[0] = d[k][bi];
      if (dual) lane[1] = d[k + 4][bi];
      else      lane[1] = 1'($urandom);
    end
    if (trail) begin
      for (int t = 0; t < 3 * W; t++) begin
        drv_edge();
        lane = 2'($urandom);
      end
    end
  endtask

  task automatic drain();
    int guard = 0;
    while (exp_q.size() != 0 && guard < 20000) begin
      @(posedge sys_clk);
      guard++;
    end
    repeat (60) @(posedge sys_clk);
    check(rx_cnt == exp_total, "R4", "word count after trailing bits", rx_cnt, exp_total);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge sys_clk);
    #1;
    check(valid_o == 0, "R9", "valid_o in reset", valid_o, 0);
    check(frame_done_o == 0, "R9", "frame_done_o in reset", frame_done_o, 0);
    check(overrun_o == 0, "R9", "overrun_o in reset", overrun_o, 0);
    #50 rst_n = 1;
    repeat (10) @(posedge sys_clk);
    #1;
    check(valid_o == 0 && overrun_o == 0, "R9", "outputs after reset", {valid_o, overrun_o}, 0);

    // R1 R2 single lane, rising edge
    tag = "R2";
    rise_sel = 1;
    send_frame(0, 8 * W, 1);
    drain();
    send_frame(0, 8 * W, 1);
    drain();

    // R3 dual lane, rising edge
    tag = "R3";
    send_frame(1, 4 * W, 1);
    drain();

    // R5 falling-edge sampling, both lane modes
    tag = "R5";
    repeat (4) @(negedge dclk);
    rise_sel = 0;
    repeat (4) @(negedge dclk);
    send_frame(0, 8 * W, 1);
    drain();
    send_frame(1, 4 * W, 1);
    drain();
    check(overrun_o == 0, "R8", "no overrun on clean frames", overrun_o, 0);

    // R8 overrun: truncated frame interrupted by a new strobe
    tag = "R8";
    rise_sel = 1;
    repeat (4) @(negedge dclk);
    send_frame(0, W + W / 2, 0);
    send_frame(0, 8 * W, 1);
    drain();
    check(overrun_o == 1, "R8", "overrun flag set", overrun_o, 1);
    tag = "R3";
    send_frame(1, 4 * W, 1);
    drain();
    check(overrun_o == 1, "R8", "overrun flag sticky", overrun_o, 1);

    finish_run();
  end
endmodule